// File: doc/BRIEF.md
# Contiguous Unit Allocator with Selectable Placement

The block manages a pool of equal-sized allocation units through an occupancy map that holds one bit per unit. A bit at 1 marks a unit as taken and a bit at 0 marks it as free. A client issues allocate requests for a number of adjacent free units, and release requests that give a start index and a length. The placement policy travels with each allocate request: lowest-addressed fit, tightest fit or loosest fit.

An allocate request starts a walk over the map that covers one unit per clock. During the walk the block follows the free run it is currently in. When a used unit or the top of the map ends that run, the run is offered to a policy picker. After the last unit the block reports a start index and a success flag. One cycle later it marks the granted units as taken. A release needs no walk: the named range is freed in the accepting cycle. The whole map is visible at all times on a plain status output.

Requests enter through a valid/ready port. The request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the response has been taken, so at most one request is in flight. Responses leave through a valid/ready port. While `rsp_ready` is low, `rsp_valid`, `rsp_ok` and `rsp_start` hold their values, and no new request is taken.

Top module: `unit_pool_alloc`

## Requirements
- R1: After reset the map is all zeros (every unit free), `req_ready` is 1 and `rsp_valid` is 0.
- R2: With `req_op`=0 (allocate) and `req_mode`=0 (lowest fit), the grant is the start of the lowest-addressed free run whose length is at least `req_len`. Mode code 3 behaves the same way.
- R3: With `req_mode`=1 (tightest fit), the grant is the start of the shortest free run whose length is at least `req_len`. When two such runs have the same length, the lower-addressed run wins.
- R4: With `req_mode`=2 (loosest fit), the grant is the start of the longest free run, and only if that run is at least `req_len` long. When two runs have the same length, the lower-addressed run wins. A free run that reaches the top unit counts as a run.
- R5: An allocate request fails (`rsp_ok`=0) when no single free run is long enough, even if the total free space would be enough. After a failed request the map is unchanged.
- R6: An allocate with `req_len` of 0 or above UNITS fails without a walk. Its response is valid on the edge that accepts the request.
- R7: On a successful allocate, units `rsp_start` to `rsp_start+req_len-1` become 1 one clock edge after `rsp_valid` rises. No other bit changes.
- R8: A release (`req_op`=1) with nonzero length and `req_start+req_len` no greater than UNITS clears that range on the accepting edge and responds with `rsp_ok`=1. Any other release responds with `rsp_ok`=0 and leaves the map unchanged.
- R9: `req_ready` is low from acceptance until the response handshake. While `rsp_valid` is high and `rsp_ready` is low, the response fields hold their values.
- R10: The response to a valid-length allocate becomes valid UNITS clock edges after the accepting edge, whatever the policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 1 | 0 allocate, 1 release |
| req_mode | input | 2 | Placement policy: 0 lowest, 1 tightest, 2 loosest, 3 as 0 |
| req_start | input | IDXW (6) | First unit of a release |
| req_len | input | LENW (7) | Number of units |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Client takes the response |
| rsp_ok | output | 1 | Request succeeded |
| rsp_start | output | IDXW (6) | Granted or released start index (0 on allocate failure) |
| occupancy | output | UNITS (64) | Current map, bit i for unit i |

## Verification
All three placement policies are run on one fragmented map. The map has free runs of lengths 3, 6, 4, 6, 4 and a final run of 7 that reaches the top unit. Sizes are chosen so that each policy picks a different run, which shows the three modes apart and also exercises the tie rule. A request for 8 units fails on that map although more than 8 units are free, which separates a contiguous search from a free-unit count. Bad lengths, releases out of range and a held response cover the fast-fail path, the release path and back-pressure.

// File: rtl/unit_alloc_pkg.sv
package unit_alloc_pkg;

  typedef enum logic [1:0] {
    FIT_LOWEST = 2'd0,
    FIT_TIGHT  = 2'd1,
    FIT_LOOSE  = 2'd2,
    FIT_SPARE  = 2'd3
  } fit_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_RESP = 2'd2
  } alloc_state_e;

  localparam logic OP_ALLOC = 1'b0;
  localparam logic OP_FREE  = 1'b1;

endpackage

// File: rtl/run_tracker.sv
module run_tracker #(
  parameter int UNITS = 64,
  parameter int IDXW  = $clog2(UNITS),
  parameter int LENW  = $clog2(UNITS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            step,
  input  logic            unit_used,
  input  logic [IDXW-1:0] idx,
  output logic            close_vld,
  output logic [IDXW-1:0] close_start,
  output logic [LENW-1:0] close_len
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(UNITS - 1);

  logic [IDXW-1:0] run_start_q;
  logic [LENW-1:0] run_len_q;
  logic [IDXW-1:0] grow_start;
  logic [LENW-1:0] grow_len;
  logic            at_top;

  assign at_top     = (idx == LAST_IDX);
  assign grow_start = (run_len_q == '0) ? idx : run_start_q;
  assign grow_len   = run_len_q + LENW'(1);

  always_comb begin
    close_vld   = 1'b0;
    close_start = run_start_q;
    close_len   = run_len_q;
    if (step) begin
      if (unit_used) begin
        close_vld = (run_len_q != '0);
      end else if (at_top) begin
        close_vld   = 1'b1;
        close_start = grow_start;
        close_len   = grow_len;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      run_start_q <= '0;
      run_len_q   <= '0;
    end else if (step) begin
      if (unit_used) begin
        run_len_q <= '0;
      end else begin
        run_start_q <= grow_start;
        run_len_q   <= grow_len;
      end
    end
  end
endmodule

// File: rtl/fit_picker.sv
module fit_picker
  import unit_alloc_pkg::*;
#(
  parameter int UNITS = 64,
  parameter int IDXW  = $clog2(UNITS),
  parameter int LENW  = $clog2(UNITS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  fit_mode_e       mode,
  input  logic [LENW-1:0] need,
  input  logic            cand_vld,
  input  logic [IDXW-1:0] cand_start,
  input  logic [LENW-1:0] cand_len,
  output logic            nxt_found,
  output logic [IDXW-1:0] nxt_start
);
  logic            found_q;
  logic [IDXW-1:0] start_q;
  logic [LENW-1:0] len_q;
  logic            fits;
  logic            beats;
  logic [LENW-1:0] nxt_len;

  assign fits = cand_vld && (cand_len >= need);

  always_comb begin
    unique case (mode)
      FIT_TIGHT: beats = !found_q || (cand_len < len_q);
      FIT_LOOSE: beats = !found_q || (cand_len > len_q);
      default:   beats = !found_q;
    endcase
  end

  always_comb begin
    nxt_found = found_q;
    nxt_start = start_q;
    nxt_len   = len_q;
    if (fits && beats) begin
      nxt_found = 1'b1;
      nxt_start = cand_start;
      nxt_len   = cand_len;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      found_q <= 1'b0;
      start_q <= '0;
      len_q   <= '0;
    end else begin
      found_q <= nxt_found;
      start_q <= nxt_start;
      len_q   <= nxt_len;
    end
  end
endmodule

// File: rtl/span_mask.sv
module span_mask #(
  parameter int UNITS = 64,
  parameter int IDXW  = $clog2(UNITS),
  parameter int LENW  = $clog2(UNITS + 1)
) (
  input  logic [IDXW-1:0]  start,
  input  logic [LENW-1:0]  len,
  output logic [UNITS-1:0] mask
);
  localparam int SUMW = LENW + 1;

  logic [SUMW-1:0] lo;
  logic [SUMW-1:0] hi;

  assign lo = SUMW'(start);
  assign hi = lo + SUMW'(len);

  for (genvar i = 0; i < UNITS; i++) begin : g_bit
    assign mask[i] = (SUMW'(i) >= lo) && (SUMW'(i) < hi);
  end
endmodule

// File: rtl/unit_pool_alloc.sv
module unit_pool_alloc
  import unit_alloc_pkg::*;
#(
  parameter int UNITS = 64,
  parameter int IDXW  = $clog2(UNITS),
  parameter int LENW  = $clog2(UNITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_op,
  input  logic [1:0]       req_mode,
  input  logic [IDXW-1:0]  req_start,
  input  logic [LENW-1:0]  req_len,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_ok,
  output logic [IDXW-1:0]  rsp_start,
  output logic [UNITS-1:0] occupancy
);
  localparam int              SUMW     = LENW + 1;
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(UNITS - 1);

  alloc_state_e    state_q;
  logic [UNITS-1:0] occ_q;
  logic [IDXW-1:0] idx_q;
  logic [LENW-1:0] need_q;
  fit_mode_e       mode_q;
  logic            res_ok_q;
  logic [IDXW-1:0] res_start_q;
  logic            commit_q;

  logic            accept;
  logic            scanning;
  logic            len_bad;
  logic            free_ok;
  logic            close_vld;
  logic [IDXW-1:0] close_start;
  logic [LENW-1:0] close_len;
  logic            nxt_found;
  logic [IDXW-1:0] nxt_start;
  logic [IDXW-1:0] m_start;
  logic [LENW-1:0] m_len;
  logic [UNITS-1:0] m_bits;

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_ok    = res_ok_q;
  assign rsp_start = res_start_q;
  assign occupancy = occ_q;

  assign accept   = req_valid && req_ready;
  assign scanning = (state_q == ST_SCAN);
  assign len_bad  = (req_len == '0) || (req_len > LENW'(UNITS));
  assign free_ok  = (req_len != '0) &&
                    ((SUMW'(req_start) + SUMW'(req_len)) <= SUMW'(UNITS));

  assign m_start = (state_q == ST_IDLE) ? req_start : res_start_q;
  assign m_len   = (state_q == ST_IDLE) ? req_len   : need_q;

  run_tracker #(.UNITS(UNITS), .IDXW(IDXW), .LENW(LENW)) u_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (accept),
    .step       (scanning),
    .unit_used  (occ_q[idx_q]),
    .idx        (idx_q),
    .close_vld  (close_vld),
    .close_start(close_start),
    .close_len  (close_len)
  );

  fit_picker #(.UNITS(UNITS), .IDXW(IDXW), .LENW(LENW)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (accept),
    .mode      (mode_q),
    .need      (need_q),
    .cand_vld  (close_vld),
    .cand_start(close_start),
    .cand_len  (close_len),
    .nxt_found (nxt_found),
    .nxt_start (nxt_start)
  );

  span_mask #(.UNITS(UNITS), .IDXW(IDXW), .LENW(LENW)) u_mask (
    .start(m_start),
    .len  (m_len),
    .mask (m_bits)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      occ_q       <= '0;
      idx_q       <= '0;
      need_q      <= '0;
      mode_q      <= FIT_LOWEST;
      res_ok_q    <= 1'b0;
      res_start_q <= '0;
      commit_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            commit_q <= 1'b0;
            if (req_op == OP_FREE) begin
              if (free_ok) occ_q <= occ_q & ~m_bits;
              res_ok_q    <= free_ok;
              res_start_q <= req_start;
              state_q     <= ST_RESP;
            end else begin
              need_q <= req_len;
              mode_q <= fit_mode_e'(req_mode);
              if (len_bad) begin
                res_ok_q    <= 1'b0;
                res_start_q <= '0;
                state_q     <= ST_RESP;
              end else begin
                idx_q   <= '0;
                state_q <= ST_SCAN;
              end
            end
          end
        end
        ST_SCAN: begin
          idx_q <= idx_q + IDXW'(1);
          if (idx_q == LAST_IDX) begin
            res_ok_q    <= nxt_found;
            res_start_q <= nxt_found ? nxt_start : '0;
            commit_q    <= nxt_found;
            state_q     <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (commit_q) begin
            occ_q    <= occ_q | m_bits;
            commit_q <= 1'b0;
          end
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/unit_pool_alloc_checker.sv
module unit_pool_alloc_checker #(
  parameter int UNITS = 64,
  parameter int IDXW  = $clog2(UNITS),
  parameter int LENW  = $clog2(UNITS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_op,
  input logic [LENW-1:0]  req_len,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_ok,
  input logic [IDXW-1:0]  rsp_start,
  input logic [UNITS-1:0] occupancy
);
  logic            cap_free;
  logic [LENW-1:0] cap_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_free <= 1'b0;
      cap_len  <= '0;
    end else if (req_valid && req_ready) begin
      cap_free <= req_op;
      cap_len  <= req_len;
    end
  end

  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ok) && $stable(rsp_start)));

  assert_fastfail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_op && ((req_len == '0) || (req_len > LENW'(UNITS))))
      |=> (rsp_valid && !rsp_ok));

  assert_fail_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |=> $stable(occupancy));

  assert_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && rsp_ok && !cap_free)
      |=> ($countones(occupancy) == $countones($past(occupancy)) + int'(cap_len)));
endmodule

bind unit_pool_alloc unit_pool_alloc_checker #(.UNITS(UNITS), .IDXW(IDXW), .LENW(LENW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_op   (req_op),
  .req_len  (req_len),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_ok   (rsp_ok),
  .rsp_start(rsp_start),
  .occupancy(occupancy)
);

// File: tb/unit_pool_alloc_test.sv
`timescale 1ns/1ps
module unit_pool_alloc_test;
  localparam int UNITS = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_op = 1'b0;
  logic [1:0]  req_mode = 2'd0;
  logic [5:0]  req_start = '0;
  logic [6:0]  req_len = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_ok;
  logic [5:0]  rsp_start;
  logic [63:0] occupancy;

  int errors = 0;
  int checks = 0;
  logic [63:0] model = '0;
  logic [63:0] pat;

  always #2 clk = ~clk;

  unit_pool_alloc uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_mode(req_mode), .req_start(req_start), .req_len(req_len),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ok(rsp_ok),
    .rsp_start(rsp_start), .occupancy(occupancy)
  );

  function automatic logic [63:0] span(input int s, input int l);
    logic [63:0] m = '0;
    for (int i = 0; i < 64; i++) if (i >= s && i < s + l) m[i] = 1'b1;
    return m;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic op, input logic [1:0] mode, input int st, input int len,
                        output logic ok, output int gs, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_mode = mode;
    req_start = st[5:0]; req_len = len[6:0];
    lat = 0;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      lat++;
    end while (!rsp_valid && lat < 300);
    ok = rsp_ok;
    gs = int'(rsp_start);
    @(negedge clk);
  endtask

  task automatic build(input logic [63:0] target);
    logic ok; int gs, lat, i, s;
    do_req(1'b1, 2'd0, 0, 64, ok, gs, lat);
    do_req(1'b0, 2'd0, 0, 64, ok, gs, lat);
    i = 0;
    while (i < 64) begin
      if (!target[i]) begin
        s = i;
        while (i < 64 && !target[i]) i++;
        do_req(1'b1, 2'd0, s, i - s, ok, gs, lat);
      end else i++;
    end
    model = target;
  endtask

  task automatic alloc_case(input string tag, input logic [1:0] mode, input int n,
                            input logic exp_ok, input int exp_start);
    logic ok; int gs, lat;
    do_req(1'b0, mode, 0, n, ok, gs, lat);
    chk({tag, " ok"}, ok, exp_ok);
    if (exp_ok) begin
      chk({tag, " start"}, gs, exp_start);
      model = model | span(exp_start, n);
    end
    chk({tag, " map"}, occupancy, model);
  endtask

  task automatic t_reset;
    chk("R1 ready", req_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 map", occupancy, 0);
  endtask

  task automatic t_lowest;
    logic ok; int gs, lat;
    do_req(1'b0, 2'd0, 0, 64, ok, gs, lat);
    chk("R10 latency", lat, UNITS + 1);
    chk("R2 whole ok", ok, 1);
    chk("R7 whole map", occupancy, {64{1'b1}});
    do_req(1'b0, 2'd0, 0, 1, ok, gs, lat);
    chk("R5 full fails", ok, 0);
    build(pat); alloc_case("R2 n4", 2'd0, 4, 1'b1, 10);
    build(pat); alloc_case("R2 n2", 2'd0, 2, 1'b1, 3);
    build(pat); alloc_case("R2 mode3", 2'd3, 5, 1'b1, 10);
    build(pat); alloc_case("R2 top run", 2'd0, 7, 1'b1, 57);
  endtask

  task automatic t_tight;
    logic ok; int gs, lat;
    build(pat);
    do_req(1'b0, 2'd1, 0, 4, ok, gs, lat);
    chk("R10 tight latency", lat, UNITS + 1);
    chk("R3 tie start", gs, 20);
    model = model | span(20, 4);
    chk("R3 map", occupancy, model);
    build(pat); alloc_case("R3 n5", 2'd1, 5, 1'b1, 10);
    build(pat); alloc_case("R3 n3", 2'd1, 3, 1'b1, 3);
  endtask

  task automatic t_loose;
    build(pat);
    alloc_case("R4 top run", 2'd2, 2, 1'b1, 57);
    alloc_case("R4 tie", 2'd2, 1, 1'b1, 10);
    build(pat); alloc_case("R4 too big", 2'd2, 8, 1'b0, 0);
  endtask

  task automatic t_frag;
    build(pat);
    alloc_case("R5 lowest n8", 2'd0, 8, 1'b0, 0);
    alloc_case("R5 tight n8", 2'd1, 8, 1'b0, 0);
  endtask

  task automatic t_badlen;
    logic ok; int gs, lat;
    build(pat);
    do_req(1'b0, 2'd0, 0, 0, ok, gs, lat);
    chk("R6 len0 latency", lat, 1);
    chk("R6 len0 ok", ok, 0);
    do_req(1'b0, 2'd1, 0, 65, ok, gs, lat);
    chk("R6 len65 latency", lat, 1);
    chk("R6 len65 ok", ok, 0);
    chk("R6 map", occupancy, model);
  endtask

  task automatic t_release;
    logic ok; int gs, lat;
    build(pat);
    do_req(1'b1, 2'd0, 0, 8, ok, gs, lat);
    chk("R8 latency", lat, 1);
    chk("R8 ok", ok, 1);
    model = model & ~span(0, 8);
    chk("R8 map", occupancy, model);
    do_req(1'b1, 2'd0, 60, 5, ok, gs, lat);
    chk("R8 range ok", ok, 0);
    chk("R8 range map", occupancy, model);
    do_req(1'b1, 2'd0, 12, 0, ok, gs, lat);
    chk("R8 len0 ok", ok, 0);
    chk("R8 len0 map", occupancy, model);
  endtask

  task automatic t_backpressure;
    int n; int st0;
    build(pat);
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 1'b0; req_mode = 2'd0; req_len = 7'd2;
    n = 0;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      n++;
    end while (!rsp_valid && n < 300);
    st0 = int'(rsp_start);
    chk("R9 start", st0, 3);
    chk("R7 not yet", occupancy, model);
    model = model | span(3, 2);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R9 held", rsp_valid, 1);
      chk("R9 busy", req_ready, 0);
      chk("R9 stable", rsp_start, st0);
      if (k == 0) chk("R7 next edge", occupancy, model);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9 released", rsp_valid, 0);
    chk("R9 ready again", req_ready, 1);
  endtask

  initial begin
    #(4ns * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    pat = '1 & ~span(3, 3) & ~span(10, 6) & ~span(20, 4)
             & ~span(30, 6) & ~span(40, 4) & ~span(57, 7);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lowest();
    t_tight();
    t_loose();
    t_frag();
    t_badlen();
    t_release();
    t_backpressure();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule